// File: doc/BRIEF.md
# SDRAM Data-Side Pipeline

This block carries the data words between a memory controller's host side and the DQ/DQM bus of a 16-bit single-data-rate SDRAM. The controller's command logic issues read and write column commands through a registered output stage. This block registers the host's per-beat data, byte enables and beat strobes in that same stage, so everything it drives onto the device bus lines up with the command the device sees.

On writes the word and its byte mask are driven in the same device cycle as the command, with zero delay between command and data. The mask is applied at once. On reads the block drives the mask early enough for the device's two-clock output-disable delay to hit the right word. It then tracks each beat through a chain of valid bits tapped at the run-time read latency (2 or 3). The captured word is presented with a valid flag and per-byte valid bits. Bytes masked off on a read are returned as zero.

Top module: `sdram_dpath`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `dq_oe`, `dqm`, `rd_valid` and `rd_be_q` are all zero.
- R2: A write beat sampled at a clock edge appears on the device bus for the whole following cycle. `dq_oe` is 1, `dq_out` equals the host word, and `dqm` equals the inverse of `wr_be`. Bit 0 is the lower byte (bits 7:0) and bit 1 is the upper byte (bits 15:8), and a mask bit of 1 means that byte is masked.
- R3: In any cycle that carries no write beat, `dq_oe` is 0 and `dq_out` is zero. This includes the whole latency window of a read.
- R4: With `cfg_rl3`=0 (latency 2), a read beat sampled at edge t makes `rd_valid` high for exactly the cycle after edge t+3. `rd_data` is then taken from `dq_in` at edge t+3.
- R5: With `cfg_rl3`=1 (latency 3), a read beat sampled at edge t makes `rd_valid` high for exactly the cycle after edge t+4. `rd_data` is then taken from `dq_in` at edge t+4.
- R6: In cycles without a write beat, `dqm` carries the inverse of a read beat's `rd_be`. At latency 2 it appears in the cycle after the beat's sampling edge, and at latency 3 it appears one cycle later than that. Either way the device latches it two clocks before it returns that beat's word. With no such read mask due, `dqm` is zero.
- R7: For a captured word, `rd_be_q` repeats the beat's byte enables. A disabled byte reads as zero, and an enabled byte carries the value the device drove.
- R8: Read beats on consecutive cycles produce `rd_valid` on consecutive cycles, one word per beat, in issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rl3 | input | 1 | Read latency select: 0 = 2 clocks, 1 = 3 clocks |
| wr_beat | input | 1 | Host presents one write data beat |
| wr_data | input | 16 | Write word |
| wr_be | input | 2 | Write byte enables (1 = write byte) |
| rd_beat | input | 1 | Host issues one read beat |
| rd_be | input | 2 | Read byte enables (1 = keep byte) |
| dq_out | output | 16 | Device-side write data |
| dq_oe | output | 1 | Device-side data output enable |
| dqm | output | 2 | Device-side byte mask lines |
| dq_in | input | 16 | Device-side read data |
| rd_valid | output | 1 | Captured read word is valid |
| rd_data | output | 16 | Captured read word, masked bytes zeroed |
| rd_be_q | output | 2 | Byte-valid bits of the captured word |

## Verification
The properties assume several things about the host. `cfg_rl3` does not change while a read beat is still in flight. `wr_beat` and `rd_beat` are never high together. No write beat is issued until the last read beat has been at least latency+2 cycles in the past. Under those rules the read mask and the write mask never compete for `dqm`.

The stimulus meets these rules by construction. It builds random read bursts, write bursts and idle runs, inserts idle cycles before any write that follows a read, and changes the latency only after a long idle drain. The device model decides which bytes it returns from the `dqm` it saw two clocks before each return. So a misplaced read mask shows up as a poisoned byte.

// File: rtl/sdram_dpath.sv
module sdram_dpath #(
  parameter int DQ_W   = 16,
  parameter int MAX_RL = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_rl3,
  input  logic            wr_beat,
  input  logic [DQ_W-1:0] wr_data,
  input  logic [DQ_W/8-1:0] wr_be,
  input  logic            rd_beat,
  input  logic [DQ_W/8-1:0] rd_be,
  output logic [DQ_W-1:0] dq_out,
  output logic            dq_oe,
  output logic [DQ_W/8-1:0] dqm,
  input  logic [DQ_W-1:0] dq_in,
  output logic            rd_valid,
  output logic [DQ_W-1:0] rd_data,
  output logic [DQ_W/8-1:0] rd_be_q
);
  localparam int NB = DQ_W / 8;
  localparam int SR = MAX_RL + 1;

  logic [SR-1:0]   vld_sr;
  logic [NB-1:0]   msk_sr [SR];
  logic            wr_q;
  logic [DQ_W-1:0] wdat_q;
  logic [NB-1:0]   wmsk_q;

  int unsigned rl;
  assign rl = cfg_rl3 ? 3 : 2;

  logic            tap_v;
  logic [NB-1:0]   tap_m;
  logic [NB-1:0]   pre_m;
  assign tap_v = vld_sr[rl];
  assign tap_m = msk_sr[rl];
  assign pre_m = msk_sr[rl-2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_sr <= '0;
      for (int k = 0; k < SR; k++) msk_sr[k] <= '0;
      wr_q   <= 1'b0;
      wdat_q <= '0;
      wmsk_q <= '0;
    end else begin
      vld_sr    <= {vld_sr[SR-2:0], rd_beat};
      msk_sr[0] <= rd_beat ? ~rd_be : '0;
      for (int k = 1; k < SR; k++) msk_sr[k] <= msk_sr[k-1];
      wr_q   <= wr_beat;
      wdat_q <= wr_beat ? wr_data : '0;
      wmsk_q <= wr_beat ? ~wr_be : '0;
    end
  end

  assign dq_oe  = wr_q;
  assign dq_out = wdat_q;
  assign dqm    = wr_q ? wmsk_q : pre_m;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_be_q  <= '0;
    end else begin
      rd_valid <= tap_v;
      rd_be_q  <= tap_v ? ~tap_m : '0;
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_data[b*8 +: 8] <= '0;
      else        rd_data[b*8 +: 8] <= (tap_v && !tap_m[b]) ? dq_in[b*8 +: 8] : 8'h00;
    end
  end
endmodule

// File: rtl/sdram_dpath_chk.sv
module sdram_dpath_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_rl3,
  input logic       wr_beat,
  input logic [1:0] wr_be,
  input logic       rd_beat,
  input logic [1:0] rd_be,
  input logic       dq_oe,
  input logic [1:0] dqm,
  input logic       rd_valid,
  input logic [1:0] rd_be_q
);
  logic [2:0] age;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) age <= '0;
    else if (age != 3'd7) age <= age + 3'd1;

  always @(posedge clk)
    if (!rst_n) p_reset_r1: assert (!dq_oe && dqm == 2'b00 && !rd_valid && rd_be_q == 2'b00);

  p_oe_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd1) |-> (dq_oe == $past(wr_beat)));

  p_wr_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd1 && $past(wr_beat)) |-> (dqm == ~$past(wr_be)));

  p_rd_lat2_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd4 && !cfg_rl3) |-> (rd_valid == $past(rd_beat, 4)));

  p_rd_lat3_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd5 && cfg_rl3) |-> (rd_valid == $past(rd_beat, 5)));

  p_rd_dqm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd1 && !cfg_rl3 && !dq_oe && $past(rd_beat)) |-> (dqm == ~$past(rd_be)));

  p_be_track_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd4 && !cfg_rl3 && rd_valid) |-> (rd_be_q == $past(rd_be, 4)));
endmodule

bind sdram_dpath sdram_dpath_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_rl3(cfg_rl3), .wr_beat(wr_beat), .wr_be(wr_be),
  .rd_beat(rd_beat), .rd_be(rd_be), .dq_oe(dq_oe), .dqm(dqm),
  .rd_valid(rd_valid), .rd_be_q(rd_be_q)
);

// File: tb/sim_sdram_dpath.sv
module sim_sdram_dpath;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_rl3 = 1'b0;
  logic        wr_beat = 1'b0;
  logic [15:0] wr_data = '0;
  logic [1:0]  wr_be = '0;
  logic        rd_beat = 1'b0;
  logic [1:0]  rd_be = '0;
  logic [15:0] dq_out;
  logic        dq_oe;
  logic [1:0]  dqm;
  logic [15:0] dq_in = '0;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic [1:0]  rd_be_q;

  always #10 clk = ~clk;

  sdram_dpath u0 (.*);

  int checks = 0, fails = 0;
  bit done = 0;
  int unsigned ecnt = 0;
  always @(posedge clk) ecnt <= ecnt + 1;

  bit          h_rd [16];
  logic [1:0]  h_rbe [16];
  logic [15:0] h_rw [16];
  bit          h_wr [16];
  logic [1:0]  h_wbe [16];
  logic [15:0] h_wd [16];
  logic [1:0]  dqm_hist [16];
  int cl = 2;
  int cool = 0;
  bit prev_v = 0;

  function automatic logic [15:0] exp_word(input logic [15:0] w, input logic [1:0] be);
    return {be[1] ? w[15:8] : 8'h00, be[0] ? w[7:0] : 8'h00};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] ex);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at edge %0d", req, act, ex, ecnt);
    end
  endtask

  task automatic clear_hist();
    for (int i = 0; i < 16; i++) begin
      h_rd[i] = 0; h_rbe[i] = 0; h_rw[i] = 0; h_wr[i] = 0; h_wbe[i] = 0; h_wd[i] = 0; dqm_hist[i] = 0;
    end
  endtask

  task automatic step(input bit rd, input logic [1:0] rbe, input bit wr, input logic [1:0] wbe, input logic [15:0] wd);
    int n, s, sv, sm, sd, nx;
    logic [1:0] edqm;
    logic [15:0] dw;
    bit ev;
    string tg;
    @(negedge clk);
    n = int'(ecnt);
    if (h_wr[n & 15]) begin
      chk(dq_oe == 1'b1, "R2", dq_oe, 1);
      chk(dq_out == h_wd[n & 15], "R2", dq_out, h_wd[n & 15]);
      chk(dqm == ~h_wbe[n & 15], "R2", dqm, ~h_wbe[n & 15]);
    end else begin
      chk(dq_oe == 1'b0 && dq_out == 16'h0, "R3", {dq_oe, dq_out}, 0);
      sm = (n + 16 - (cl - 2)) & 15;
      edqm = h_rd[sm] ? ~h_rbe[sm] : 2'b00;
      chk(dqm == edqm, "R6", dqm, edqm);
    end
    sv = (n + 16 - 1 - cl) & 15;
    ev = h_rd[sv];
    tg = ev && prev_v ? "R8" : (cl == 2 ? "R4" : "R5");
    chk(rd_valid == ev, tg, rd_valid, ev);
    if (ev) begin
      chk(rd_be_q == h_rbe[sv], "R7", rd_be_q, h_rbe[sv]);
      chk(rd_data == exp_word(h_rw[sv], h_rbe[sv]), "R7", rd_data, exp_word(h_rw[sv], h_rbe[sv]));
    end
    prev_v = ev;
    dqm_hist[n & 15] = dqm;
    s = (n + 16 - cl) & 15;
    sd = (n + 16 - 2) & 15;
    dw = h_rw[s];
    if (dqm_hist[sd][0]) dw[7:0] = 8'hA5;
    if (dqm_hist[sd][1]) dw[15:8] = 8'hA5;
    dq_in = h_rd[s] ? dw : 16'hDEAD;
    nx = (n + 1) & 15;
    h_rd[nx] = rd; h_rbe[nx] = rbe; h_rw[nx] = 16'($urandom);
    h_wr[nx] = wr; h_wbe[nx] = wbe; h_wd[nx] = wd;
    rd_beat = rd; rd_be = rbe; wr_beat = wr; wr_be = wbe; wr_data = wd;
    if (rd) cool = cl + 2; else if (cool > 0) cool--;
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) step(0, 2'b00, 0, 2'b00, 16'h0);
  endtask

  task automatic rand_traffic(input int segs);
    for (int g = 0; g < segs; g++) begin
      int kind, len;
      kind = int'($urandom % 3);
      len = 1 + int'($urandom % 8);
      if (kind == 0)
        for (int i = 0; i < len; i++) step(1, 2'($urandom), 0, 2'b00, 16'h0);
      else if (kind == 1) begin
        while (cool > 0) idle(1);
        for (int i = 0; i < len; i++) step(0, 2'b00, 1, 2'($urandom), 16'($urandom));
      end else idle(len % 3);
    end
    idle(8);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    clear_hist();
    repeat (3) @(negedge clk);
    chk(dq_oe == 0 && dqm == 0 && rd_valid == 0 && rd_be_q == 0, "R1", {dq_oe, dqm, rd_valid, rd_be_q}, 0);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    chk(dq_oe == 0 && dqm == 0 && rd_valid == 0 && rd_be_q == 0, "R1", {dq_oe, dqm, rd_valid, rd_be_q}, 0);
    @(negedge clk);
    ecnt = 1;
    clear_hist();
    cl = 2; cfg_rl3 = 0;
    step(1, 2'b01, 0, 2'b00, 16'h0);
    step(1, 2'b10, 0, 2'b00, 16'h0);
    step(1, 2'b00, 0, 2'b00, 16'h0);
    step(1, 2'b11, 0, 2'b00, 16'h0);
    idle(6);
    step(0, 2'b00, 1, 2'b01, 16'h1234);
    step(0, 2'b00, 1, 2'b10, 16'hABCD);
    idle(3);
    rand_traffic(150);
    cl = 3; cfg_rl3 = 1;
    step(1, 2'b10, 0, 2'b00, 16'h0);
    step(1, 2'b01, 0, 2'b00, 16'h0);
    step(1, 2'b11, 0, 2'b00, 16'h0);
    idle(6);
    step(0, 2'b00, 1, 2'b11, 16'h55AA);
    idle(3);
    rand_traffic(150);
    cl = 2; cfg_rl3 = 0;
    rand_traffic(60);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule